// File: doc/BRIEF.md
# Dithered Second-Order Delta-Sigma Divider Controller with Noise-Cancel Error

This block sets the modulus of a fractional-N feedback divider once per reference cycle. A constant unsigned fraction `frac_word`, read as a value between 0 and 1 in steps of 1/65536, is turned into a stream of small signed integers. The divider adds each of them to its integer modulus. The shaping is second order: the quantization error of each step is fed back through (1 − z⁻¹)², so the error in the divider sequence ends up at high frequency. A free-running 8-bit pseudo-random sequence dithers each quantizer decision, which breaks up idle tones. The dither sits inside the shaped error, so it is shaped as well.

The same block also produces the data for a cancellation DAC that sits ahead of the loop filter. Each cycle it adds up how far the integer it issued lies from the requested fraction. That running total is the phase error the next charge-pump pulse will carry. Its upper ten bits are exported for the DAC, and its sign bit is exported to steer an adaptive gain-calibration current. The accumulation is delayed by one cycle: each total covers every divider value issued before the current one. All outputs come straight from registers.

Top module: `dsm_cancel_mod`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the edge clears all state. From the next sample `div_offset`, `cancel_word` and `cancel_sign` read 0, and this holds whether reset comes at start-up or in the middle of a run.
- R2: `div_offset` is a 3-bit two's-complement integer, and its value always lies in -2..+3.
- R3: Let E be the running total, taken over every divider value issued since reset except the current one, of (F − 65536·Y). Here Y is that earlier `div_offset` value and F is the `frac_word` sampled at the edge that produced it. `cancel_word` equals floor(E/256) as a 10-bit two's-complement value, which is bits 17..8 of an 18-bit E.
- R4: `cancel_sign` is 1 exactly when E is negative.
- R5: After N cycles from reset with a constant word F, the sum of the `div_offset` values differs from round(N·F/65536) by at most 1.
- R6: The quantizer adds a signed 8-bit pseudo-random dither value whose generator never holds all zeros. Despite the dither, |E| never exceeds 65790, so `cancel_word` stays within -257..+256.
- R7: With `frac_word` held at 0 from reset, `div_offset` and `cancel_word` stay 0 on every cycle, because the dither alone never moves the quantizer off zero.
- R8: A change of `frac_word` shows in the `div_offset` loaded at the very next edge. Starting from an all-zero state, the first value after a switch to 0xFFFF is +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frac_word | input | 16 | Unsigned fractional frequency word, value/65536 |
| div_offset | output | 3 | Signed divider offset added to the integer modulus |
| cancel_word | output | 10 | Upper bits of the accumulated phase error, two's complement |
| cancel_sign | output | 1 | 1 when the accumulated phase error is negative |

## Verification
In one clock edge the block does two things: it loads a new divider value computed from the current word, and it folds the previous value and the word that produced it into the phase-error total. A change of `frac_word` therefore lands in both paths at the same edge, but each path uses a different word. The step scenario provokes this by switching words repeatedly in the middle of a run. The bench pairs every observed `div_offset` with the word it drove on that edge and then compares `cancel_word` and `cancel_sign` exactly, cycle by cycle, against its own running total. Any error in how the word is staged shows up as a mismatch within one cycle.

// File: rtl/dsm_pkg.sv
`timescale 1ns/1ps
package dsm_pkg;

  // Feedback tap mask for a left-shifting Fibonacci generator of width w.
  // The top bit is always tapped, so the update is invertible and a
  // non-zero state can never reach zero.
  function automatic logic [15:0] lfsr_taps(input int unsigned w);
    case (w)
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0829;
      16:      return 16'hD008;
      default: return 16'h00B8;
    endcase
  endfunction

  // Largest magnitude of the shaped quantizer error (dither included),
  // in units of 2^-frac_w.
  function automatic longint err_limit(input int unsigned frac_w,
                                       input int unsigned dith_w);
    return (longint'(1) << (frac_w - 1)) + (longint'(1) << (dith_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/dsm_lfsr.sv
`timescale 1ns/1ps
module dsm_lfsr #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  localparam logic [15:0]  TAP_ALL  = dsm_pkg::lfsr_taps(W);
  localparam logic [W-1:0] TAPS     = TAP_ALL[W-1:0];
  localparam logic [W-1:0] SEED_USE = (SEED == '0) ? W'(1) : SEED;

  logic [W-1:0] state_q;
  logic [W-1:0] tapped;
  logic [W:0]   parity;

  assign tapped    = state_q & TAPS;
  assign parity[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_par
      assign parity[gi+1] = parity[gi] ^ tapped[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SEED_USE;
    else        state_q <= {state_q[W-2:0], parity[W]};
  end

  assign state = state_q;

  // R6: the dither generator never sticks in the all-zero state
  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

endmodule

// File: rtl/dsm_core.sv
`timescale 1ns/1ps
module dsm_core #(
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned DITH_W = 8,
  parameter int unsigned Y_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FRAC_W-1:0]     frac_in,
  input  logic [DITH_W-1:0]     dither,
  output logic signed [Y_W-1:0] y_next
);
  localparam int unsigned ACC_W   = FRAC_W + 4;
  localparam int unsigned ERR_W   = FRAC_W + 2;
  localparam longint      ERR_LIM = dsm_pkg::err_limit(FRAC_W, DITH_W);
  localparam logic signed [ACC_W-1:0] HALF  = ACC_W'(longint'(1) << (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] Q_MIN = ACC_W'(-2);
  localparam logic signed [ACC_W-1:0] Q_MAX = ACC_W'(3);
  localparam logic signed [ERR_W-1:0] E_HI  = ERR_W'(ERR_LIM);
  localparam logic signed [ERR_W-1:0] E_LO  = ERR_W'(-ERR_LIM);

  function automatic logic signed [ACC_W-1:0] widen_err(input logic signed [ERR_W-1:0] e);
    return {{(ACC_W-ERR_W){e[ERR_W-1]}}, e};
  endfunction

  // x - 2*e[n-1] + e[n-2]: the error-feedback form of (1 - z^-1)^2
  function automatic logic signed [ACC_W-1:0] shape_sum(
    input logic [FRAC_W-1:0]      x,
    input logic signed [ERR_W-1:0] p1,
    input logic signed [ERR_W-1:0] p2);
    logic signed [ACC_W-1:0] xw;
    xw = {{(ACC_W-FRAC_W){1'b0}}, x};
    return xw - (widen_err(p1) <<< 1) + widen_err(p2);
  endfunction

  // Round-to-nearest integer level of (u + dither)
  function automatic logic signed [ACC_W-1:0] quant_level(
    input logic signed [ACC_W-1:0] u,
    input logic [DITH_W-1:0]       d);
    logic signed [ACC_W-1:0] dw;
    dw = {{(ACC_W-DITH_W){d[DITH_W-1]}}, d};
    return (u + dw + HALF) >>> FRAC_W;
  endfunction

  // Error fed back: issued level minus undithered input, so dither is shaped
  function automatic logic signed [ACC_W-1:0] quant_err(
    input logic signed [ACC_W-1:0] q,
    input logic signed [ACC_W-1:0] u);
    return (q <<< FRAC_W) - u;
  endfunction

  logic signed [ERR_W-1:0] e1_q, e2_q;
  logic signed [ACC_W-1:0] u_w, q_w, e_w;
  logic signed [ERR_W-1:0] e_now;

  assign u_w    = shape_sum(frac_in, e1_q, e2_q);
  assign q_w    = quant_level(u_w, dither);
  assign e_w    = quant_err(q_w, u_w);
  assign e_now  = e_w[ERR_W-1:0];
  assign y_next = q_w[Y_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e1_q <= '0;
      e2_q <= '0;
    end else begin
      e1_q <= e_now;
      e2_q <= e1_q;
    end
  end

  // R2: the full-width quantizer level never leaves -2..+3
  p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (q_w >= Q_MIN) && (q_w <= Q_MAX));

  // R6: the stored shaped error stays inside its bound
  p_err_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (e1_q >= E_LO) && (e1_q <= E_HI));

endmodule

// File: rtl/dsm_err_acc.sv
`timescale 1ns/1ps
module dsm_err_acc #(
  parameter int unsigned FRAC_W = 16,
  parameter int unsigned DITH_W = 8,
  parameter int unsigned Y_W    = 3,
  parameter int unsigned OUT_W  = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FRAC_W-1:0]     frac_q,
  input  logic signed [Y_W-1:0] y_q,
  output logic [OUT_W-1:0]      cancel_word,
  output logic                  cancel_sign
);
  localparam int unsigned ECP_W = FRAC_W + 2;
  localparam int unsigned T_W   = FRAC_W + Y_W + 1;
  localparam longint      C_LIM = 2 * dsm_pkg::err_limit(FRAC_W, DITH_W);
  localparam logic signed [ECP_W-1:0] C_HI = ECP_W'(C_LIM);
  localparam logic signed [ECP_W-1:0] C_LO = ECP_W'(-C_LIM);

  // Phase step of one reference cycle: requested fraction minus issued integer
  function automatic logic signed [T_W-1:0] cycle_error(
    input logic [FRAC_W-1:0]      a,
    input logic signed [Y_W-1:0]  y);
    logic signed [T_W-1:0] aw, yw;
    aw = {{(T_W-FRAC_W){1'b0}}, a};
    yw = {{(T_W-Y_W){y[Y_W-1]}}, y};
    return aw - (yw <<< FRAC_W);
  endfunction

  logic signed [ECP_W-1:0] ecp_q;
  logic signed [T_W-1:0]   term_w, sum_w;

  assign term_w = cycle_error(frac_q, y_q);
  assign sum_w  = {{(T_W-ECP_W){ecp_q[ECP_W-1]}}, ecp_q} + term_w;

  always_ff @(posedge clk) begin
    if (!rst_n) ecp_q <= '0;
    else        ecp_q <= sum_w[ECP_W-1:0];
  end

  assign cancel_word = ecp_q[ECP_W-1 -: OUT_W];
  assign cancel_sign = ecp_q[ECP_W-1];

  // R6: the accumulated phase error stays bounded by twice the error limit
  p_cancel_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ecp_q >= C_LO) && (ecp_q <= C_HI));

endmodule

// File: rtl/dsm_cancel_mod.sv
`timescale 1ns/1ps
module dsm_cancel_mod #(
  parameter int unsigned FRAC_W    = 16,
  parameter int unsigned DITH_W    = 8,
  parameter int unsigned Y_W       = 3,
  parameter int unsigned OUT_W     = 10,
  parameter logic [DITH_W-1:0] DITH_SEED = DITH_W'(1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FRAC_W-1:0]     frac_word,
  output logic signed [Y_W-1:0] div_offset,
  output logic [OUT_W-1:0]      cancel_word,
  output logic                  cancel_sign
);
  logic [DITH_W-1:0]     dither_w;
  logic signed [Y_W-1:0] y_next_w;
  logic signed [Y_W-1:0] y_q;
  logic [FRAC_W-1:0]     frac_q;

  dsm_lfsr #(.W(DITH_W), .SEED(DITH_SEED)) u_dither (
    .clk   (clk),
    .rst_n (rst_n),
    .state (dither_w)
  );

  dsm_core #(.FRAC_W(FRAC_W), .DITH_W(DITH_W), .Y_W(Y_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .frac_in (frac_word),
    .dither  (dither_w),
    .y_next  (y_next_w)
  );

  // Divider value and the word that produced it advance together
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q    <= '0;
      frac_q <= '0;
    end else begin
      y_q    <= y_next_w;
      frac_q <= frac_word;
    end
  end

  dsm_err_acc #(.FRAC_W(FRAC_W), .DITH_W(DITH_W), .Y_W(Y_W), .OUT_W(OUT_W)) u_acc (
    .clk         (clk),
    .rst_n       (rst_n),
    .frac_q      (frac_q),
    .y_q         (y_q),
    .cancel_word (cancel_word),
    .cancel_sign (cancel_sign)
  );

  assign div_offset = y_q;

  // R1: outputs read zero right after a reset edge
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (div_offset == '0) && (cancel_word == '0) && !cancel_sign);

endmodule

// File: tb/dsm_cancel_mod_test.sv
`timescale 1ns/1ps
module dsm_cancel_mod_test;
  localparam int CLK_P = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       frac_word = '0;
  logic signed [2:0] div_offset;
  logic [9:0]        cancel_word;
  logic              cancel_sign;

  int     n_tests = 0;
  int     n_fail  = 0;
  longint model_s = 0;
  longint sum_y   = 0;
  longint n_cyc   = 0;

  always #(CLK_P/2) clk = ~clk;

  dsm_cancel_mod uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frac_word   (frac_word),
    .div_offset  (div_offset),
    .cancel_word (cancel_word),
    .cancel_sign (cancel_sign)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frac_word = '0;
    repeat (2) @(posedge clk);
    #1;
    check(div_offset == 3'sd0, "R1 div_offset", longint'(div_offset), 0);
    check(cancel_word == 10'd0, "R1 cancel_word", longint'(cancel_word), 0);
    check(cancel_sign == 1'b0, "R1 cancel_sign", longint'(cancel_sign), 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_s = 0;
    sum_y = 0;
    n_cyc = 0;
  endtask

  // One reference cycle: drive the word, sample after the edge, compare.
  task automatic step(input logic [15:0] a, output int yv);
    longint exp_w;
    @(negedge clk);
    frac_word = a;
    @(posedge clk);
    #1;
    yv = int'(div_offset);
    exp_w = model_s >>> 8;
    check(longint'($signed(cancel_word)) == exp_w, "R3 cancel_word", longint'($signed(cancel_word)), exp_w);
    check(cancel_sign == (model_s < 0), "R4 cancel_sign", longint'(cancel_sign), longint'(model_s < 0));
    check(yv >= -2 && yv <= 3, "R2 div_offset range", yv, 0);
    model_s = model_s + longint'(a) - 65536 * longint'(yv);
    sum_y   = sum_y + yv;
    n_cyc   = n_cyc + 1;
    check(model_s <= 65790 && model_s >= -65790, "R6 phase error bound", model_s, 65790);
  endtask

  task automatic mean_check(input logic [15:0] a);
    longint exp_sum;
    longint diff;
    exp_sum = (n_cyc * longint'(a) + 32768) / 65536;
    diff = sum_y - exp_sum;
    check(diff <= 1 && diff >= -1, "R5 mean of div_offset", sum_y, exp_sum);
  endtask

  task automatic test_reset();
    apply_reset();
  endtask

  task automatic test_zero();
    int yv;
    apply_reset();
    for (int i = 0; i < 300; i++) begin
      step(16'h0000, yv);
      check(yv == 0, "R7 zero word keeps div_offset 0", yv, 0);
      check(cancel_word == 10'd0, "R7 zero word keeps cancel_word 0", longint'(cancel_word), 0);
    end
  endtask

  task automatic test_const(input logic [15:0] a);
    int yv;
    apply_reset();
    for (int i = 0; i < 1500; i++) step(a, yv);
    mean_check(a);
  endtask

  task automatic test_step();
    int yv;
    apply_reset();
    for (int i = 0; i < 10; i++) step(16'h0000, yv);
    step(16'hFFFF, yv);
    check(yv == 1, "R8 first value after switch", yv, 1);
    for (int i = 0; i < 460; i++) begin
      step(((i / 23) % 2 == 0) ? 16'h2000 : 16'hE000, yv);
    end
  endtask

  task automatic test_midreset();
    int yv;
    apply_reset();
    for (int i = 0; i < 200; i++) step(16'h8000, yv);
    apply_reset();
    for (int i = 0; i < 60; i++) step(16'h8000, yv);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_zero();
    test_const(16'h8000);
    test_const(16'h0001);
    test_const(16'hFFFF);
    test_const(16'h5555);
    test_step();
    test_midreset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule